// File: doc/BRIEF.md
# Local Quadword Cache

This block sits beside a stack executor. It keeps the four words that hold locals 0 to 3 of the current frame in registers. Those words lie at word offsets 4 to 7 from the frame base, and because the base is quadword aligned they form exactly one aligned quadword. A load of any of these locals is answered from the registers with no memory traffic. A store to one of them updates its register and then writes all four registers back to memory as a single four-beat burst.

Other agents and other paths of the executor can also write memory. The block watches the address of every such store on a snoop input. When a snooped store lands in the cached quadword, the block reloads all four words from memory. A double-word store that crosses a quadword boundary shows up as two single-word snoops, and each of them is tested on its own. After reset the block fills itself from the frame given on `frame_base`. Choosing which frame to cache is left to the surroundings.

Top module: `local_quad_cache`

## Requirements
- R1: After reset is released, the block issues a four-beat read burst to word addresses base+4, base+5, base+6 and base+7, in ascending order. Requests stay stalled (`req_ready` low) until that fill ends.
- R2: A load (`req_store`=0) with index 0..3 accepted on one clock edge raises `rsp_valid` for exactly the following cycle. `rsp_data` then carries the cached word, and the load makes no memory access.
- R3: A store (`req_store`=1) to index i replaces cached word i, so a later load of i returns the stored value.
- R4: An accepted store is followed on the next cycle by a write burst (`mem_we`=1). The burst puts all four cached words at base+4..base+7, in that order. No further store is accepted until the burst ends, although loads still are.
- R5: A snoop whose address satisfies (addr>>2) == (base>>2)+1 triggers a four-beat read burst of that quadword. Later loads return the refreshed memory contents.
- R6: A snoop to any other quadword, including the one holding the frame base itself, causes no memory access and leaves the cached words unchanged.
- R7: Snoops on consecutive cycles are each compared. A miss followed at once by a hit, as a boundary-crossing double store produces, still triggers the refill.
- R8: A load that arrives during a refill is stalled until the refill ends. It then returns the refreshed word.
- R9: A snoop hit that arrives during a refill causes one more complete four-beat refill after the current one.
- R10: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_we` and `mem_wdata` hold. Each granted cycle advances the burst by one word, and a burst is never cut short.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_base | input | AW | Word address of the current frame base, quadword aligned |
| req_valid | input | 1 | Executor request present |
| req_store | input | 1 | 1 = store to a local, 0 = load |
| req_idx | input | 2 | Local index 0..3 |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| rsp_valid | output | 1 | Load data valid, one cycle after acceptance |
| rsp_data | output | DW | Loaded word |
| snoop_valid | input | 1 | Another path stored a word this cycle |
| snoop_addr | input | AW | Word address of that store |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | AW | Word address of the current beat |
| mem_wdata | output | DW | Write data of the current beat |
| mem_rdata | input | DW | Read data, valid in a granted read beat |
| mem_gnt | input | 1 | Beat completes on this edge |

## Verification
A wrong cached word shows up as a wrong `rsp_data` one cycle after the next load of that local. It also shows up in memory, within four granted beats of the next local store, because the write-back carries every register. A snoop comparison that is off by one quadword either starts a read burst where none belongs, visible on `mem_req` on the very next cycle, or leaves a stale value that a following load exposes. A burst counter that slips shows as a repeated or skipped `mem_addr` inside a burst, or as a word written to the wrong offset.

// File: rtl/lqc_pkg.sv
package lqc_pkg;
  // Number of words held, and the bits that index them.
  localparam int QWORDS = 4;
  localparam int QBITS  = $clog2(QWORDS);
  // Locals 0..3 start one quadword above the frame base.
  localparam int LOCAL_QUAD_OFS = 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WBACK = 2'd2
  } lqc_state_e;
endpackage

// File: rtl/lqc_snoop_cmp.sv
module lqc_snoop_cmp
  import lqc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]       frame_base,
  input  logic                snoop_valid,
  input  logic [AW-1:0]       snoop_addr,
  output logic [AW-QBITS-1:0] quad_idx,
  output logic                snoop_hit
);
  localparam int QAW = AW - QBITS;

  // Quadword number of the cached locals.
  assign quad_idx  = frame_base[AW-1:QBITS] + QAW'(LOCAL_QUAD_OFS);
  // A single-word store lies inside exactly one quadword.
  assign snoop_hit = snoop_valid && (snoop_addr[AW-1:QBITS] == quad_idx);
endmodule

// File: rtl/lqc_word_bank.sv
module lqc_word_bank
  import lqc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_en,
  input  logic [QBITS-1:0] st_sel,
  input  logic [DW-1:0]    st_data,
  input  logic             fl_en,
  input  logic [QBITS-1:0] fl_sel,
  input  logic [DW-1:0]    fl_data,
  output logic [DW-1:0]    words [QWORDS]
);
  for (genvar g = 0; g < QWORDS; g++) begin : g_word
    logic          en;
    logic [DW-1:0] d;

    always_comb begin
      en = 1'b0;
      d  = words[g];
      if (fl_en && (fl_sel == QBITS'(g))) begin
        en = 1'b1;
        d  = fl_data;
      end else if (st_en && (st_sel == QBITS'(g))) begin
        en = 1'b1;
        d  = st_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  words[g] <= '0;
      else if (en) words[g] <= d;
    end
  end

  // R3: a local store and a refill beat never land in the same cycle
  p_one_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_en && fl_en));
endmodule

// File: rtl/lqc_seq.sv
module lqc_seq
  import lqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snoop_hit,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             mem_gnt,
  output lqc_state_e       state,
  output logic [QBITS-1:0] beat,
  output logic             in_burst,
  output logic             req_ready,
  output logic             acc_load,
  output logic             acc_store,
  output logic             fill_en
);
  lqc_state_e       state_n;
  logic [QBITS-1:0] beat_n;
  logic             pend_q, pend_n;
  logic             last_beat, refill;

  assign in_burst = (state != ST_IDLE);

  always_comb begin
    last_beat = in_burst && mem_gnt && (beat == QBITS'(QWORDS - 1));
    refill    = pend_q || snoop_hit;
    req_ready = !refill &&
                ((state == ST_IDLE) || ((state == ST_WBACK) && !req_store));
    acc_load  = req_valid && req_ready && !req_store;
    acc_store = req_valid && req_ready && req_store;
    fill_en   = (state == ST_FILL) && mem_gnt;

    state_n = state;
    beat_n  = beat;
    pend_n  = pend_q;
    case (state)
      ST_IDLE: begin
        if (refill) begin
          state_n = ST_FILL;
          beat_n  = '0;
          pend_n  = 1'b0;
        end else if (acc_store) begin
          state_n = ST_WBACK;
          beat_n  = '0;
        end
      end
      default: begin
        if (last_beat) begin
          beat_n  = '0;
          pend_n  = 1'b0;
          state_n = refill ? ST_FILL : ST_IDLE;
        end else begin
          if (mem_gnt) beat_n = beat + 1'b1;
          pend_n = refill;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FILL;
      beat   <= '0;
      pend_q <= 1'b0;
    end else begin
      state  <= state_n;
      beat   <= beat_n;
      pend_q <= pend_n;
    end
  end

  // R5: a hit while idle starts a refill on the next cycle
  p_hit_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && snoop_hit |=> (state == ST_FILL));

  // R9: a hit during a refill keeps the block refilling
  p_hit_in_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) && snoop_hit |=> (state == ST_FILL));
endmodule

// File: rtl/local_quad_cache.sv
module local_quad_cache
  import lqc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    frame_base,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [1:0]       req_idx,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  input  logic             snoop_valid,
  input  logic [AW-1:0]    snoop_addr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_gnt
);
  localparam int QAW = AW - QBITS;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic [QAW-1:0]   quad_idx;
  logic             snoop_hit;
  lqc_state_e       state;
  logic [QBITS-1:0] beat;
  logic             in_burst, acc_load, acc_store, fill_en;
  logic [DW-1:0]    words [QWORDS];

  lqc_snoop_cmp #(.AW(AW)) u_cmp (
    .frame_base (frame_base),
    .snoop_valid(snoop_valid),
    .snoop_addr (snoop_addr),
    .quad_idx   (quad_idx),
    .snoop_hit  (snoop_hit)
  );

  lqc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .snoop_hit(snoop_hit),
    .req_valid(req_valid),
    .req_store(req_store),
    .mem_gnt  (mem_gnt),
    .state    (state),
    .beat     (beat),
    .in_burst (in_burst),
    .req_ready(req_ready),
    .acc_load (acc_load),
    .acc_store(acc_store),
    .fill_en  (fill_en)
  );

  lqc_word_bank #(.DW(DW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_i),
    .st_en  (acc_store),
    .st_sel (QBITS'(req_idx)),
    .st_data(req_wdata),
    .fl_en  (fill_en),
    .fl_sel (beat),
    .fl_data(mem_rdata),
    .words  (words)
  );

  // Memory side: one word per beat, ascending within the quadword.
  assign mem_req   = in_burst && rst_i;
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = {quad_idx, beat};
  assign mem_wdata = words[beat];

  // Load response register.
  logic          rsp_valid_n;
  logic [DW-1:0] rsp_data_n;
  always_comb begin
    rsp_valid_n = acc_load;
    rsp_data_n  = rsp_data;
    if (acc_load) rsp_data_n = words[QBITS'(req_idx)];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_valid_n;
      rsp_data  <= rsp_data_n;
    end
  end

  // R2: an accepted load answers on the next cycle
  p_load_answers_r2: assert property (@(posedge clk) disable iff (!rst_i)
    req_valid && req_ready && !req_store |=> rsp_valid);

  // R4: an accepted store opens a write burst at the first word
  p_store_writes_r4: assert property (@(posedge clk) disable iff (!rst_i)
    req_valid && req_ready && req_store |=>
      mem_req && mem_we && (mem_addr[QBITS-1:0] == '0));

  // R4: no store is taken while a write burst runs
  p_no_store_in_wb_r4: assert property (@(posedge clk) disable iff (!rst_i)
    mem_req && mem_we |-> !(req_valid && req_ready && req_store));

  // R8: nothing is accepted during a refill
  p_fill_stalls_r8: assert property (@(posedge clk) disable iff (!rst_i)
    mem_req && !mem_we |-> !req_ready);

  // R10: an ungranted beat holds its address, direction and data
  p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rst_i)
    mem_req && !mem_gnt |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10: a burst runs to its last word
  p_burst_runs_r10: assert property (@(posedge clk) disable iff (!rst_i)
    mem_req && mem_gnt && (mem_addr[QBITS-1:0] != QBITS'(QWORDS - 1)) |=> mem_req);
endmodule

// File: tb/sim_local_quad_cache.sv
module sim_local_quad_cache;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [AW-1:0] BASE = 16'h0010;
  localparam int LOC0 = 16'h0014;

  localparam logic [3:0] K_LD = 4'd0;  // a=index, e=expected data
  localparam logic [3:0] K_ST = 4'd1;  // a=index, v=data
  localparam logic [3:0] K_SN = 4'd2;  // a=addr, v=data, e=expected read beats
  localparam logic [3:0] K_PK = 4'd3;  // a=addr, v=data, silent memory change
  localparam int NV = 18;
  localparam logic [51:0] VEC [NV] = '{
    {K_LD, 16'h0000, 16'h0000, 16'h1014},
    {K_LD, 16'h0003, 16'h0000, 16'h1017},
    {K_ST, 16'h0001, 16'hAAAA, 16'h0000},
    {K_LD, 16'h0001, 16'h0000, 16'hAAAA},
    {K_LD, 16'h0002, 16'h0000, 16'h1016},
    {K_SN, 16'h0016, 16'h5555, 16'h0004},
    {K_LD, 16'h0002, 16'h0000, 16'h5555},
    {K_LD, 16'h0001, 16'h0000, 16'hAAAA},
    {K_PK, 16'h0017, 16'h9999, 16'h0000},
    {K_SN, 16'h0018, 16'h7777, 16'h0000},
    {K_SN, 16'h0013, 16'h3333, 16'h0000},
    {K_LD, 16'h0003, 16'h0000, 16'h1017},
    {K_SN, 16'h0017, 16'h9999, 16'h0004},
    {K_LD, 16'h0003, 16'h0000, 16'h9999},
    {K_ST, 16'h0003, 16'hBEEF, 16'h0000},
    {K_LD, 16'h0003, 16'h0000, 16'hBEEF},
    {K_SN, 16'h0010, 16'h1234, 16'h0000},
    {K_LD, 16'h0000, 16'h0000, 16'h1014}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_store, req_ready, rsp_valid;
  logic [1:0]    req_idx;
  logic [DW-1:0] req_wdata, rsp_data;
  logic          snoop_valid;
  logic [AW-1:0] snoop_addr;
  logic          mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  local_quad_cache #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_base(BASE),
    .req_valid(req_valid), .req_store(req_store), .req_idx(req_idx),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
  );

  // Memory model
  logic [DW-1:0] model [64];
  int  rd_beats = 0, wr_beats = 0, addr_err = 0;
  logic gnt_q = 1'b1;
  bit   stall_mode = 1'b0;
  assign mem_gnt   = gnt_q;
  assign mem_rdata = model[mem_addr[5:0]];

  always @(negedge clk) gnt_q <= stall_mode ? ~gnt_q : 1'b1;

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        if (int'(mem_addr) != LOC0 + (wr_beats % 4)) addr_err <= addr_err + 1;
        model[mem_addr[5:0]] <= mem_wdata;
        wr_beats <= wr_beats + 1;
      end else begin
        if (int'(mem_addr) != LOC0 + (rd_beats % 4)) addr_err <= addr_err + 1;
        rd_beats <= rd_beats + 1;
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mem_req || !req_ready) @(negedge clk);
  endtask

  task automatic do_load(input logic [1:0] idx, output logic [DW-1:0] data,
                         output bit stalled, output bit got);
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_idx = idx;
    #1;
    stalled = !req_ready;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    got  = rsp_valid;
    data = rsp_data;
    req_valid = 1'b0;
  endtask

  task automatic do_store(input logic [1:0] idx, input logic [DW-1:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b1; req_idx = idx; req_wdata = val;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    while (mem_req) @(negedge clk);
  endtask

  task automatic do_snoop(input logic [AW-1:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    model[a[5:0]] = v;
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic load_check(input string tag, input logic [1:0] idx, input int exp);
    logic [DW-1:0] d; bit st, got; int r0;
    r0 = rd_beats;
    do_load(idx, d, st, got);
    check_eq({tag, " rsp_valid"}, int'(got), 1);
    check_eq({tag, " data"}, int'(d), exp);
    check_eq({tag, " no memory read"}, rd_beats - r0, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d; bit st, got; int r0, w0;
    for (int i = 0; i < 64; i++) model[i] = DW'(16'h1000 + i);
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_idx = '0;
    req_wdata = '0; snoop_valid = 1'b0; snoop_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 ready in reset", int'(req_ready), 0);
    check_eq("R1 rsp_valid in reset", int'(rsp_valid), 0);
    check_eq("R1 mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    wait_idle();
    check_eq("R1 fill beats", rd_beats, 4);
    check_eq("R1 fill addresses", addr_err, 0);

    for (int n = 0; n < NV; n++) begin
      logic [3:0] k; logic [15:0] a, v, e;
      {k, a, v, e} = VEC[n];
      case (k)
        K_LD: load_check("R2/R3 load", a[1:0], int'(e));
        K_ST: begin
          w0 = wr_beats;
          do_store(a[1:0], v);
          check_eq("R4 write beats", wr_beats - w0, 4);
          check_eq("R4 memory word", int'(model[LOC0 + int'(a[1:0])]), int'(v));
        end
        K_SN: begin
          r0 = rd_beats;
          do_snoop(a, v);
          wait_idle();
          check_eq("R5/R6 refill beats", rd_beats - r0, int'(e));
        end
        default: model[a[5:0]] = v;
      endcase
    end

    // R7: miss then hit on consecutive cycles
    r0 = rd_beats;
    @(negedge clk);
    model[6'h13] = 16'h1111; snoop_valid = 1'b1; snoop_addr = 16'h0013;
    @(negedge clk);
    model[6'h14] = 16'h4444; snoop_addr = 16'h0014;
    @(negedge clk);
    snoop_valid = 1'b0;
    wait_idle();
    check_eq("R7 refill beats", rd_beats - r0, 4);
    load_check("R7 load", 2'd0, 16'h4444);

    // R8: load issued during refill
    r0 = rd_beats;
    do_snoop(16'h0015, 16'h2222);
    do_load(2'd1, d, st, got);
    check_eq("R8 load stalled", int'(st), 1);
    check_eq("R8 load data", int'(d), 16'h2222);
    check_eq("R8 refill beats", rd_beats - r0, 4);

    // R9: hit during refill
    wait_idle();
    r0 = rd_beats;
    @(negedge clk);
    model[6'h16] = 16'h6161; snoop_valid = 1'b1; snoop_addr = 16'h0016;
    @(negedge clk);
    model[6'h17] = 16'h7171; snoop_addr = 16'h0017;
    @(negedge clk);
    snoop_valid = 1'b0;
    wait_idle();
    check_eq("R9 refill beats", rd_beats - r0, 8);
    load_check("R9 load", 2'd2, 16'h6161);
    load_check("R9 load", 2'd3, 16'h7171);

    // R10: write burst with a stalling memory
    stall_mode = 1'b1;
    w0 = wr_beats;
    do_store(2'd0, 16'hC0DE);
    stall_mode = 1'b0;
    check_eq("R10 write beats", wr_beats - w0, 4);
    check_eq("R10 word0", int'(model[6'h14]), 16'hC0DE);
    check_eq("R10 word1", int'(model[6'h15]), 16'h2222);
    check_eq("R10 word2", int'(model[6'h16]), 16'h6161);
    check_eq("R10 word3", int'(model[6'h17]), 16'h7171);
    check_eq("R10 beat addresses", addr_err, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule